// File: doc/BRIEF.md
# Cache-Line Burst Address Sequencer

This block produces the word address for each data phase of a memory burst. A one-cycle start pulse supplies the first word address, an ordering mode and a cache line size in words. From the next cycle, `cur_addr` holds the first word. Each advance strobe moves it to the next word of the chosen order.

Three orders are available. The linear order counts upward. Wrap and toggle are critical-word-first orders. Both begin at the requested word and walk every word of that cache line before moving on. Once a line is done, the walk resumes in the following line at the same offset it began with.

The line size may not be one of the supported sizes, or the mode code may be the reserved one. In either case the block raises `single_only`. The burst must then stop after its first word, and the address no longer moves.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst` is high at a rising edge, `cur_addr` becomes 0 and `single_only` becomes 0 on that edge.
- R2: A start pulse loads the burst. On the following cycle `cur_addr` equals `start_addr`. If `adv` is high in the same cycle as `start`, the start is taken and the advance is ignored.
- R3: With mode code 0 (linear), each accepted advance raises `cur_addr` by exactly one, including across line boundaries.
- R4: With mode code 1 (wrap) and line size L, the k-th word after the start has in-line index (s + k) mod L, where s is the start's in-line index.
- R5: With mode code 2 (toggle) and line size L, the k-th word of a line has in-line index s XOR k, for k from 0 to L-1.
- R6: In wrap and toggle modes, after L words the sequence moves to the next line (line base plus L) and begins again at index s.
- R7: When the start's in-line index is zero, the linear, wrap and toggle modes produce identical address sequences.
- R8: Line sizes 4, 8, 16 and 32 words are supported. A start with any other size sets `single_only` on the next cycle.
- R9: Mode code 3 is unsupported. A start with it sets `single_only` on the next cycle, whatever the line size.
- R10: While `single_only` is high, advances leave `cur_addr` unchanged. The flag holds until the next start.
- R11: In a cycle with neither `start` nor `adv`, `cur_addr` and `single_only` keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse that loads a new burst |
| start_addr | input | ADDR_W | Word address of the first data phase |
| start_mode | input | 2 | Order: 0 linear, 1 wrap, 2 toggle, 3 unsupported |
| start_lsz | input | LSZ_W | Cache line size in words |
| adv | input | 1 | A data phase completed; step to the next word |
| cur_addr | output | ADDR_W | Word address of the current data phase |
| single_only | output | 1 | Burst must end after its first word |

## Verification
The two events that can share a cycle are a start pulse and an advance strobe. The same collision arises when a new burst is started while the previous one is still stepping. The bench raises `adv` together with `start`, both mid-burst and right after an unsupported start. Its reference model applies the rule that the start wins: the next cycle must show the new start address, with no step applied. A second collision occurs when an advance completes a line. Here the line jump and the critical-word offset take effect in the same step. The bench judges this against the computed address of word k on every clock, over bursts several lines long.

// File: rtl/bseq_pkg.sv
package bseq_pkg;

    // smallest and largest supported cache line, as log2 of words
    localparam int unsigned LINE_LG_MIN = 2;
    localparam int unsigned LINE_LG_MAX = 5;
    localparam int unsigned IDX_W       = LINE_LG_MAX;
    localparam int unsigned N_SIZES     = LINE_LG_MAX - LINE_LG_MIN + 1;

    typedef enum logic [1:0] {
        ORD_LINEAR = 2'd0,
        ORD_WRAP   = 2'd1,
        ORD_TOGGLE = 2'd2,
        ORD_RSVD   = 2'd3
    } order_e;

    // in-line walk state of a burst
    typedef struct packed {
        order_e           mode;
        logic [IDX_W-1:0] first;  // in-line index of the critical word
        logic [IDX_W-1:0] cnt;    // words already taken from the current line
        logic [IDX_W-1:0] mask;   // line size minus one
    } walk_t;

    function automatic logic order_ok(order_e m);
        return m != ORD_RSVD;
    endfunction

    function automatic logic [IDX_W-1:0] size_mask(int unsigned lg);
        return IDX_W'((1 << lg) - 1);
    endfunction

endpackage

// File: rtl/bseq_lsz_decode.sv
module bseq_lsz_decode
    import bseq_pkg::*;
#(
    parameter int unsigned LSZ_W = 8
) (
    input  logic [LSZ_W-1:0] lsz,
    output logic             ok,
    output logic [IDX_W-1:0] mask
);

    logic [N_SIZES-1:0] hit;

    for (genvar g = 0; g < N_SIZES; g++) begin : g_size
        localparam int unsigned LG = LINE_LG_MIN + g;
        assign hit[g] = (lsz == LSZ_W'(1 << LG));
    end

    assign ok = |hit;

    always_comb begin
        mask = '0;
        for (int i = 0; i < N_SIZES; i++) begin
            if (hit[i]) mask = size_mask(LINE_LG_MIN + i);
        end
    end

endmodule

// File: rtl/bseq_step.sv
module bseq_step
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32
) (
    input  walk_t             walk,
    input  logic [ADDR_W-1:0] base,
    output walk_t             walk_nxt,
    output logic [ADDR_W-1:0] base_nxt
);

    localparam int unsigned PAD_W = ADDR_W - IDX_W;

    logic              line_done;
    logic [ADDR_W-1:0] line_len;

    assign line_done = (walk.cnt == walk.mask);
    assign line_len  = {{PAD_W{1'b0}}, walk.mask} + ADDR_W'(1);

    always_comb begin
        walk_nxt = walk;
        base_nxt = base;
        if (line_done) begin
            walk_nxt.cnt = '0;
            base_nxt     = base + line_len;
        end else begin
            walk_nxt.cnt = walk.cnt + IDX_W'(1);
        end
    end

endmodule

// File: rtl/bseq_index_gen.sv
module bseq_index_gen
    import bseq_pkg::*;
(
    input  walk_t          walk,
    output logic [IDX_W:0] idx
);

    logic [IDX_W-1:0] rot;
    logic [IDX_W-1:0] flip;

    assign rot  = (walk.first + walk.cnt) & walk.mask;
    assign flip = (walk.first ^ walk.cnt) & walk.mask;

    always_comb begin
        unique case (walk.mode)
            ORD_LINEAR: idx = {1'b0, walk.first} + {1'b0, walk.cnt};
            ORD_WRAP:   idx = {1'b0, rot};
            ORD_TOGGLE: idx = {1'b0, flip};
            default:    idx = {1'b0, walk.first};
        endcase
    end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LSZ_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [1:0]        start_mode,
    input  logic [LSZ_W-1:0]  start_lsz,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              single_only
);

    localparam int unsigned PAD_W = ADDR_W - IDX_W - 1;

    walk_t             walk_q, walk_n, walk_ld;
    logic [ADDR_W-1:0] base_q, base_n, base_ld, addr_q, addr_n;
    logic              single_q;
    logic              lsz_ok;
    logic [IDX_W-1:0]  ld_mask;
    logic [IDX_W:0]    idx_n;
    order_e            ld_mode;

    bseq_lsz_decode #(.LSZ_W(LSZ_W)) u_dec (
        .lsz  (start_lsz),
        .ok   (lsz_ok),
        .mask (ld_mask)
    );

    assign ld_mode       = order_e'(start_mode);
    assign walk_ld.mode  = ld_mode;
    assign walk_ld.first = start_addr[IDX_W-1:0] & ld_mask;
    assign walk_ld.cnt   = '0;
    assign walk_ld.mask  = ld_mask;
    assign base_ld       = start_addr & ~{{(PAD_W + 1){1'b0}}, ld_mask};

    bseq_step #(.ADDR_W(ADDR_W)) u_step (
        .walk     (walk_q),
        .base     (base_q),
        .walk_nxt (walk_n),
        .base_nxt (base_n)
    );

    bseq_index_gen u_idx (
        .walk (walk_n),
        .idx  (idx_n)
    );

    assign addr_n = base_n + {{PAD_W{1'b0}}, idx_n};

    always_ff @(posedge clk) begin
        if (rst) begin
            walk_q   <= '{mode: ORD_LINEAR, first: '0, cnt: '0, mask: '0};
            base_q   <= '0;
            addr_q   <= '0;
            single_q <= 1'b0;
        end else if (start) begin
            walk_q   <= walk_ld;
            base_q   <= base_ld;
            addr_q   <= start_addr;
            single_q <= !(lsz_ok && order_ok(ld_mode));
        end else if (adv && !single_q) begin
            walk_q <= walk_n;
            base_q <= base_n;
            addr_q <= addr_n;
        end
    end

    assign cur_addr    = addr_q;
    assign single_only = single_q;

endmodule

// File: rtl/bseq_chk.sv
module bseq_chk
    import bseq_pkg::*;
#(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned LSZ_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              start,
    input logic [ADDR_W-1:0] start_addr,
    input logic [1:0]        start_mode,
    input logic [LSZ_W-1:0]  start_lsz,
    input logic              adv,
    input logic [ADDR_W-1:0] cur_addr,
    input logic              single_only,
    input walk_t             walk_q
);

    logic lsz_legal;
    assign lsz_legal = ($countones(start_lsz) == 1) &&
                       (start_lsz >= LSZ_W'(4)) && (start_lsz <= LSZ_W'(32));

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cur_addr == '0) && !single_only);

    // R2
    start_load_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> cur_addr == $past(start_addr));

    // R8
    bad_size_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !lsz_legal) |=> single_only);

    // R9
    rsvd_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (start && start_mode == 2'd3) |=> single_only);

    // R10
    single_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (single_only && !start) |=> $stable(cur_addr) && single_only);

    // R11
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && !adv) |=> $stable(cur_addr) && $stable(single_only));

    // R3
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && adv && !single_only && walk_q.mode == ORD_LINEAR)
        |=> cur_addr == $past(cur_addr) + ADDR_W'(1));

    // R4
    wrap_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!start && adv && !single_only && walk_q.mode == ORD_WRAP)
        |=> (cur_addr[IDX_W-1:0] & $past(walk_q.mask)) ==
            (($past(cur_addr[IDX_W-1:0]) + IDX_W'(1)) & $past(walk_q.mask)));

endmodule

bind burst_addr_seq bseq_chk #(.ADDR_W(ADDR_W), .LSZ_W(LSZ_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .start_addr  (start_addr),
    .start_mode  (start_mode),
    .start_lsz   (start_lsz),
    .adv         (adv),
    .cur_addr    (cur_addr),
    .single_only (single_only),
    .walk_q      (walk_q)
);

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

    localparam int CLK_PERIOD = 10;
    localparam int AW = 32;
    localparam int LW = 8;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [1:0]    start_mode = '0;
    logic [LW-1:0] start_lsz = '0;
    logic          adv = 1'b0;
    logic [AW-1:0] cur_addr;
    logic          single_only;

    always #(CLK_PERIOD / 2) clk = ~clk;

    burst_addr_seq #(.ADDR_W(AW), .LSZ_W(LW)) i_burst_addr_seq (
        .clk (clk), .rst (rst), .start (start), .start_addr (start_addr),
        .start_mode (start_mode), .start_lsz (start_lsz), .adv (adv),
        .cur_addr (cur_addr), .single_only (single_only)
    );

    int total = 0;
    int bad   = 0;
    bit chk_en = 0;

    // reference model state
    logic [AW-1:0] exp_addr = '0;
    logic          exp_single = 1'b0;
    int unsigned   m_org, m_s, m_lbase, m_len, m_k, m_mode;
    string         tag = "R1";

    function automatic logic [AW-1:0] word_at(int unsigned k);
        int unsigned ln = k / m_len;
        int unsigned w  = k % m_len;
        case (m_mode)
            0: return AW'(m_org + k);
            1: return AW'(m_lbase + ln * m_len + (m_s + w) % m_len);
            default: return AW'(m_lbase + ln * m_len + (m_s ^ w));
        endcase
    endfunction

    always @(posedge clk) begin
        chk_en <= 1'b1;
        if (rst) begin
            exp_addr = '0; exp_single = 1'b0; tag = "R1";
        end else if (start) begin
            m_len  = start_lsz;
            m_mode = start_mode;
            exp_single = !((m_len == 4 || m_len == 8 || m_len == 16 || m_len == 32)
                           && m_mode != 3);
            m_org  = start_addr;
            m_s    = exp_single ? 0 : m_org % m_len;
            m_lbase = m_org - m_s;
            m_k    = 0;
            exp_addr = start_addr;
            tag = exp_single ? (m_mode == 3 ? "R9" : "R8") : "R2";
        end else if (adv && !exp_single) begin
            m_k++;
            exp_addr = word_at(m_k);
            if (m_mode == 0) tag = "R3";
            else if (m_k % m_len == 0) tag = "R6";
            else tag = (m_mode == 1) ? "R4" : "R5";
        end else begin
            tag = exp_single ? "R10" : "R11";
        end
    end

    always @(negedge clk) begin
        if (chk_en) begin
            total++;
            if (cur_addr !== exp_addr || single_only !== exp_single) begin
                bad++;
                $display("FAIL %s: addr=%h single=%b expected addr=%h single=%b",
                         tag, cur_addr, single_only, exp_addr, exp_single);
            end
        end
    end

    task automatic go(input logic [AW-1:0] a, input int m, input int l, input bit with_adv);
        start = 1'b1; start_addr = a; start_mode = 2'(m); start_lsz = LW'(l); adv = with_adv;
        @(negedge clk);
        start = 1'b0; adv = 1'b0;
    endtask

    task automatic step(input int n, input bit gaps);
        for (int i = 0; i < n; i++) begin
            adv = 1'b1;
            @(negedge clk);
            adv = 1'b0;
            if (gaps && (i % 3 == 1)) @(negedge clk);
        end
    endtask

    logic [AW-1:0] seq [3][$];

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state at the ports
        total++;
        if (cur_addr !== '0 || single_only !== 1'b0) begin
            bad++;
            $display("FAIL R1: addr=%h single=%b expected addr=0 single=0", cur_addr, single_only);
        end
        rst = 1'b0;
        @(negedge clk);

        go(32'h0000_0105, 0, 8, 0);  step(20, 0);            // R3 linear
        go(32'h0000_0203, 1, 4, 0);  step(12, 1);            // R4 R6 R11 wrap
        go(32'h0000_3005, 1, 16, 0); step(40, 0);
        go(32'h0000_0405, 2, 8, 0);  step(20, 1);            // R5 R6 toggle
        go(32'h0000_051B, 2, 32, 0); step(70, 0);
        go(32'h0000_0607, 1, 8, 1);  step(3, 0);             // R2 start with adv
        go(32'h0000_0712, 2, 16, 1); step(5, 0);             // R2 restart mid-burst
        go(32'h0000_0800, 1, 12, 0); step(5, 0);             // R8 R10
        go(32'h0000_0900, 0, 0, 1);  step(3, 1);             // R8
        go(32'h0000_0A00, 2, 64, 0); step(3, 0);             // R8
        go(32'h0000_0B01, 3, 8, 0);  step(4, 0);             // R9 R10
        go(32'h0000_0C03, 0, 16, 1); step(6, 0);             // R2 after single

        // R7: zero offset gives the same sequence for every mode
        for (int m = 0; m < 3; m++) begin
            go(32'h0000_1000, m, 8, 0);
            for (int i = 0; i < 20; i++) begin
                seq[m].push_back(cur_addr);
                adv = 1'b1;
                @(negedge clk);
            end
            adv = 1'b0;
        end
        for (int m = 1; m < 3; m++) begin
            for (int i = 0; i < 20; i++) begin
                total++;
                if (seq[m][i] !== seq[0][i]) begin
                    bad++;
                    $display("FAIL R7: mode %0d word %0d addr=%h expected %h",
                             m, i, seq[m][i], seq[0][i]);
                end
            end
        end

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule